// File: doc/BRIEF.md
# Port Overcurrent Fault Timer

This block supervises a single power-delivery port. An analog front end supplies two comparator flags: one for a lower "cut" threshold, above which the port may run only for a limited time, and one for a higher "limit" threshold, at which the analog loop is already regulating the current. The block integrates the time spent over each threshold in timebase ticks. When either budget is used up, it requests that the port be switched off and records which budget was exhausted.

The cut timer is a leaky integrator. It climbs one step per tick while over the threshold. When the current is back under the threshold, it drains at one sixteenth of that rate, so short repeated overloads are tolerated and a sustained high duty cycle is not. A separate limit timer runs only when the host has programmed a nonzero limit-time multiplier. With the multiplier at zero, limit events are charged to the cut timer instead.

The block also supplies the current-limit code sent to the analog side. While the port is off or still in inrush, this is a fixed inrush code. Once inrush has been reported, it is the host-programmed code. The fault bits hold until the host clears them.

Top module: `port_fault_timer`

## Requirements
- R1: While `port_on` is high and no off request is pending, each `tick` with `cut_flag` high adds one to the cut count. The tick that brings the count to `CUT_TRIP` sets `cut_fault` and `port_off_req`, both visible after that clock edge.
- R2: On a tick with the cut timer not charging and a nonzero count, a 4-bit prescaler advances. The count drops by one only on the 16th such tick. Any charging tick restarts the prescaler at zero.
- R3: The cut flag alone never changes `ilim_code`; once inrush is over, it stays at the programmed code while the cut timer runs and after it trips.
- R4: With `lim_time` (unsigned 4-bit multiplier) nonzero, `lim_flag` high on `lim_time*LIM_UNIT` consecutive ticks sets `lim_fault` and `port_off_req`. In this mode, limit events do not charge the cut timer.
- R5: With `lim_time` equal to zero, the limit timer stays idle and a tick with `lim_flag` high charges the cut timer exactly as `cut_flag` does.
- R6: While the port is on, `ilim_code` equals `INRUSH_CODE` until an `inrush_done` pulse. From the clock edge that samples the pulse, it equals `ilim_prog`.
- R7: One clock after `port_on` is sampled low, `ilim_code` returns to `INRUSH_CODE`. A later turn-on needs a fresh `inrush_done`.
- R8: Whenever `lim_flag` is sampled low, the limit timer restarts from zero, whether or not a tick is present.
- R9: A clock with `port_on` low clears both timers, the prescaler and `port_off_req`. A partly filled budget does not carry over to the next turn-on.
- R10: `cut_fault` and `lim_fault` stay set until a clock with `fault_clr` high clears them. A trip in the same clock sets them regardless of `fault_clr`.
- R11: After a synchronous reset, `port_off_req`, `cut_fault` and `lim_fault` are 0 and `ilim_code` is `INRUSH_CODE`.
- R12: Once `port_off_req` is set, both timers freeze and `port_off_req` holds until `port_on` is sampled low. No further trip occurs, even after a fault clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock timebase strobe |
| port_on | input | 1 | Port power is applied |
| cut_flag | input | 1 | Current above the cut threshold |
| lim_flag | input | 1 | Current at the limit threshold |
| lim_time | input | LT_W | Limit-time multiplier, 0 disables the limit timer |
| ilim_prog | input | IL_W | Host-programmed current-limit code |
| inrush_done | input | 1 | Pulse marking the end of inrush |
| fault_clr | input | 1 | Host clear of both fault bits |
| port_off_req | output | 1 | Request to switch the port off |
| cut_fault | output | 1 | Cut-time budget exhausted |
| lim_fault | output | 1 | Limit-time budget exhausted |
| ilim_code | output | IL_W | Current-limit code to the analog side |

## Verification
The bench builds the block with `CUT_TRIP` = 40 and `LIM_UNIT` = 3, keeping `LT_W` = 4 and `IL_W` = 8. At these values the cut trip, both edges of every limit multiplier, and drain windows longer than the 16-tick decay step all fit in a few hundred ticks. The multiplier range runs from 2 (trip after 6 ticks) to 15 (trip after 45 ticks). With 40 as the cut trip point, 15 versus 16 drain ticks after a 30-tick charge changes whether 10 more charging ticks trip the port, which exposes the exact decay ratio.

// File: rtl/port_fault_pkg.sv
package port_fault_pkg;
  // prescaler width that sets the 1/16 decay ratio of the cut timer
  localparam int unsigned DECAY_W = 4;
endpackage

// File: rtl/cut_budget_timer.sv
module cut_budget_timer
  import port_fault_pkg::*;
#(
  parameter int unsigned CUT_TRIP = 600
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  input  logic tick,
  input  logic charge,
  output logic trip
);
  localparam int unsigned CW = $clog2(CUT_TRIP + 1);
  localparam logic [CW-1:0] TRIP_M1 = CW'(CUT_TRIP - 1);
  localparam logic [CW-1:0] TRIP_V  = CW'(CUT_TRIP);

  logic [CW-1:0]      level;
  logic [DECAY_W-1:0] decay;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      level <= '0;
      decay <= '0;
    end else if (tick && !hold) begin
      if (charge) begin
        decay <= '0;
        if (level != TRIP_V) level <= level + 1'b1;
      end else if (level != '0) begin
        decay <= decay + 1'b1;
        if (decay == '1) level <= level - 1'b1;
      end
    end
  end

  assign trip = run && !hold && tick && charge && (level == TRIP_M1);

  // R1: the level never runs past the trip point
  a_r1_level_bounded: assert property (@(posedge clk) disable iff (rst)
    level <= TRIP_V);
  // R2: a draining tick before the 16th leaves the level unchanged
  a_r2_slow_drain: assert property (@(posedge clk) disable iff (rst)
    (run && !hold && tick && !charge && decay != '1) |=> level == $past(level));
  // R9: port off empties the integrator
  a_r9_off_clears: assert property (@(posedge clk) disable iff (rst)
    !run |=> (level == '0 && decay == '0));
endmodule

// File: rtl/limit_budget_timer.sv
module limit_budget_timer #(
  parameter int unsigned LIM_UNIT = 17,
  parameter int unsigned LT_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            hold,
  input  logic            tick,
  input  logic            flag,
  input  logic [LT_W-1:0] mult,
  output logic            trip
);
  localparam int unsigned MAXV = LIM_UNIT * ((1 << LT_W) - 1);
  localparam int unsigned LW   = $clog2(MAXV + 1);

  logic [LW-1:0] span;
  logic [LW-1:0] limit;
  logic          armed;

  assign armed = (mult != '0);
  assign limit = LW'(mult) * LW'(LIM_UNIT);

  always_ff @(posedge clk) begin
    if (rst || !run || !flag || !armed) begin
      span <= '0;
    end else if (tick && !hold && span != limit) begin
      span <= span + 1'b1;
    end
  end

  assign trip = run && !hold && tick && flag && armed && (span == limit - 1'b1);

  // R8: dropping the limit flag restarts the span
  a_r8_flag_drop_restart: assert property (@(posedge clk) disable iff (rst)
    !flag |=> span == '0);
  // R5: a zero multiplier keeps this timer idle
  a_r5_zero_mult_idle: assert property (@(posedge clk) disable iff (rst)
    !armed |=> span == '0);
endmodule

// File: rtl/ilim_code_select.sv
module ilim_code_select #(
  parameter int unsigned     IL_W        = 8,
  parameter logic [IL_W-1:0] INRUSH_CODE = 8'h80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            port_on,
  input  logic            inrush_done,
  input  logic [IL_W-1:0] prog,
  output logic [IL_W-1:0] code
);
  logic settled;

  always_ff @(posedge clk) begin
    if (rst) begin
      settled <= 1'b0;
      code    <= INRUSH_CODE;
    end else begin
      if (!port_on)         settled <= 1'b0;
      else if (inrush_done) settled <= 1'b1;
      code <= (port_on && (settled || inrush_done)) ? prog : INRUSH_CODE;
    end
  end

  // R7: a sampled port-off restores the inrush code
  a_r7_off_inrush: assert property (@(posedge clk) disable iff (rst)
    !port_on |=> code == INRUSH_CODE);
  // R6: before inrush completes, the code is the inrush code
  a_r6_inrush_hold: assert property (@(posedge clk) disable iff (rst)
    (port_on && !settled && !inrush_done) |=> code == INRUSH_CODE);
endmodule

// File: rtl/port_fault_timer.sv
module port_fault_timer #(
  parameter int unsigned     CUT_TRIP    = 600,
  parameter int unsigned     LIM_UNIT    = 17,
  parameter int unsigned     LT_W        = 4,
  parameter int unsigned     IL_W        = 8,
  parameter logic [IL_W-1:0] INRUSH_CODE = 8'h80
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            port_on,
  input  logic            cut_flag,
  input  logic            lim_flag,
  input  logic [LT_W-1:0] lim_time,
  input  logic [IL_W-1:0] ilim_prog,
  input  logic            inrush_done,
  input  logic            fault_clr,
  output logic            port_off_req,
  output logic            cut_fault,
  output logic            lim_fault,
  output logic [IL_W-1:0] ilim_code
);
  logic charge_cut;
  logic cut_trip;
  logic lim_trip;

  // a zero multiplier routes limit events into the cut budget
  assign charge_cut = cut_flag || (lim_flag && (lim_time == '0));

  cut_budget_timer #(.CUT_TRIP(CUT_TRIP)) u_cut (
    .clk(clk), .rst(rst), .run(port_on), .hold(port_off_req),
    .tick(tick), .charge(charge_cut), .trip(cut_trip)
  );

  limit_budget_timer #(.LIM_UNIT(LIM_UNIT), .LT_W(LT_W)) u_lim (
    .clk(clk), .rst(rst), .run(port_on), .hold(port_off_req),
    .tick(tick), .flag(lim_flag), .mult(lim_time), .trip(lim_trip)
  );

  ilim_code_select #(.IL_W(IL_W), .INRUSH_CODE(INRUSH_CODE)) u_ilim (
    .clk(clk), .rst(rst), .port_on(port_on), .inrush_done(inrush_done),
    .prog(ilim_prog), .code(ilim_code)
  );

  always_ff @(posedge clk) begin
    if (rst || !port_on) port_off_req <= 1'b0;
    else if (cut_trip || lim_trip) port_off_req <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_fault <= 1'b0;
      lim_fault <= 1'b0;
    end else begin
      cut_fault <= cut_trip || (cut_fault && !fault_clr);
      lim_fault <= lim_trip || (lim_fault && !fault_clr);
    end
  end

  // R10: fault bits are sticky without a clear
  a_r10_sticky_cut: assert property (@(posedge clk) disable iff (rst)
    (cut_fault && !fault_clr) |=> cut_fault);
  a_r10_sticky_lim: assert property (@(posedge clk) disable iff (rst)
    (lim_fault && !fault_clr) |=> lim_fault);
  // R12: the off request holds while the port stays on
  a_r12_off_holds: assert property (@(posedge clk) disable iff (rst)
    (port_off_req && port_on) |=> port_off_req);
  // R4: a limit fault can only rise with a nonzero multiplier
  a_r4_lim_needs_mult: assert property (@(posedge clk) disable iff (rst)
    $rose(lim_fault) |-> $past(lim_time) != '0);
endmodule

// File: tb/test_port_fault_timer.sv
`timescale 1ns/1ps
module test_port_fault_timer;
  localparam int unsigned CUT_TRIP = 40;
  localparam int unsigned LIM_UNIT = 3;
  localparam logic [7:0]  INRUSH   = 8'h80;
  localparam logic [7:0]  PROG     = 8'hC0;

  // row: [15] cut, [14] lim, [13:10] mult, [9:2] ticks, [1] exp cut fault, [0] exp lim fault
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0,  8'd39, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd0,  8'd40, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd0,  8'd39, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd0,  8'd40, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd2,  8'd5,  1'b0, 1'b0},
    {1'b0, 1'b1, 4'd2,  8'd6,  1'b0, 1'b1},
    {1'b0, 1'b1, 4'd15, 8'd44, 1'b0, 1'b0},
    {1'b0, 1'b1, 4'd15, 8'd45, 1'b0, 1'b1},
    {1'b1, 1'b1, 4'd2,  8'd6,  1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, port_on = 1'b0, cut_flag = 1'b0, lim_flag = 1'b0;
  logic [3:0] lim_time = '0;
  logic [7:0] ilim_prog = PROG;
  logic inrush_done = 1'b0, fault_clr = 1'b0;
  logic port_off_req, cut_fault, lim_fault;
  logic [7:0] ilim_code;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  port_fault_timer #(.CUT_TRIP(CUT_TRIP), .LIM_UNIT(LIM_UNIT), .LT_W(4), .IL_W(8),
                     .INRUSH_CODE(INRUSH)) i_port_fault_timer (
    .clk(clk), .rst(rst), .tick(tick), .port_on(port_on), .cut_flag(cut_flag),
    .lim_flag(lim_flag), .lim_time(lim_time), .ilim_prog(ilim_prog),
    .inrush_done(inrush_done), .fault_clr(fault_clr), .port_off_req(port_off_req),
    .cut_fault(cut_fault), .lim_fault(lim_fault), .ilim_code(ilim_code)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    end
  endtask

  // fresh turn-on with faults cleared and inrush finished
  task automatic power_up();
    cut_flag = 1'b0; lim_flag = 1'b0;
    port_on = 1'b0; fault_clr = 1'b1; cyc(1);
    fault_clr = 1'b0; port_on = 1'b1; cyc(1);
    inrush_done = 1'b1; cyc(1); inrush_done = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(3);
    // R11: reset state
    chk("R11 off_req", port_off_req, 0);
    chk("R11 cut_fault", cut_fault, 0);
    chk("R11 lim_fault", lim_fault, 0);
    chk("R11 ilim", ilim_code, INRUSH);
    rst = 1'b0; cyc(1);

    // R6: inrush code until done, then programmed
    port_on = 1'b1; cyc(3);
    chk("R6 inrush code", ilim_code, INRUSH);
    inrush_done = 1'b1; cyc(1); inrush_done = 1'b0;
    chk("R6 programmed code", ilim_code, PROG);
    // R7: back to inrush when off
    port_on = 1'b0; cyc(1);
    chk("R7 off inrush", ilim_code, INRUSH);
    port_on = 1'b1; cyc(2);
    chk("R7 needs new done", ilim_code, INRUSH);

    // table walk: R1 R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      power_up();
      lim_time = VEC[v][13:10];
      cut_flag = VEC[v][15];
      lim_flag = VEC[v][14];
      ticks(int'(VEC[v][9:2]));
      cut_flag = 1'b0; lim_flag = 1'b0;
      chk("R1/R5 cut_fault", cut_fault, VEC[v][1]);
      chk("R4 lim_fault", lim_fault, VEC[v][0]);
      chk("R1/R4 off_req", port_off_req, VEC[v][1] | VEC[v][0]);
      chk("R3 ilim unchanged", ilim_code, PROG);
    end
    lim_time = 4'd0;

    // R2: 16 drain ticks remove one step
    power_up();
    cut_flag = 1'b1; ticks(30);
    cut_flag = 1'b0; ticks(16);
    cut_flag = 1'b1; ticks(10);
    chk("R2 after 16 drain", cut_fault, 0);
    ticks(1);
    chk("R2 trip after extra", cut_fault, 1);
    // R2: 15 drain ticks remove nothing
    power_up();
    cut_flag = 1'b1; ticks(30);
    cut_flag = 1'b0; ticks(15);
    cut_flag = 1'b1; ticks(10);
    chk("R2 after 15 drain", cut_fault, 1);
    cut_flag = 1'b0;

    // R8: limit flag drop restarts the span
    power_up();
    lim_time = 4'd2;
    lim_flag = 1'b1; ticks(5);
    lim_flag = 1'b0; cyc(1);
    lim_flag = 1'b1; ticks(5);
    chk("R8 no trip after restart", lim_fault, 0);
    ticks(1);
    chk("R8 trip after full span", lim_fault, 1);
    lim_flag = 1'b0; lim_time = 4'd0;

    // R9: port off empties partial budget
    power_up();
    cut_flag = 1'b1; ticks(39);
    port_on = 1'b0; cyc(1);
    chk("R9 off_req clear", port_off_req, 0);
    port_on = 1'b1; ticks(1);
    chk("R9 no carry over", cut_fault, 0);
    cut_flag = 1'b0;

    // R10 / R12: sticky faults, frozen timers after trip
    power_up();
    cut_flag = 1'b1; ticks(40);
    chk("R12 off_req set", port_off_req, 1);
    ticks(3);
    chk("R10 fault sticky", cut_fault, 1);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0;
    chk("R10 cleared", cut_fault, 0);
    chk("R12 off_req holds", port_off_req, 1);
    ticks(50);
    chk("R12 no retrip", cut_fault, 0);
    cut_flag = 1'b0; port_on = 1'b0; cyc(1);
    chk("R12 off_req drops", port_off_req, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule